// File: doc/BRIEF.md
# Rotating Single-Bank Refresh Sequencer

This block sits in a low-power DRAM controller and issues refresh to one bank at a time. A free-running timer raises a refresh request once per single-bank interval, which is one bank-count-th of the full-device refresh interval. Each request goes to the next bank in a round-robin order, so every bank is refreshed once per full interval. While a bank is being refreshed, only that bank's blocked bit is set, and the scheduler can keep issuing reads, writes and activates to the other banks.

A single-bank refresh draws current in the same way as an activate. It therefore takes a slot in the rolling four-activate window, and the block emits a stamp for the window tracker in the cycle the refresh goes out. If the target bank still has an open row, the block first asks for a precharge of that bank alone and waits for the acknowledge. If the window has no free slot, or the scheduler is activating in the same cycle, the refresh waits. The busy time of a single-bank refresh is a parameter of its own. It is not derived from the all-bank refresh time, because the single-bank operation takes far longer than an even share of it.

The controller has four states. ST_IDLE waits for a due request. ST_PRECHARGE holds the precharge request until the acknowledge arrives. ST_WAIT_SLOT holds the refresh until the bank is closed, a window slot is free and the scheduler is not activating. ST_BUSY counts down the refresh busy time. The transitions are: IDLE→PRECHARGE when a request is due and the target row is open; IDLE→WAIT_SLOT when a request is due and the target row is closed; PRECHARGE→WAIT_SLOT on the acknowledge; WAIT_SLOT→PRECHARGE if the target row is open again; WAIT_SLOT→BUSY when the refresh issues; BUSY→IDLE when the count expires, which also advances the bank pointer.

Top module: `bank_refresh_seq`

## Requirements
- R1: A refresh request becomes due every REF_INTERVAL cycles. With the target rows closed, the window free and no scheduler activates, consecutive refresh commands are exactly REF_INTERVAL cycles apart.
- R2: In the cycle a refresh is issued, `bank_blocked` has exactly bit `ref_bank` set (bit i stands for bank i). That bit stays set for exactly PB_BUSY cycles, counting the issue cycle, and then clears. All other bits stay zero throughout.
- R3: `faw_stamp` is high in exactly the cycles where `ref_cmd` is high.
- R4: If the target bank has an open row, `pre_req` is raised with `pre_bank` equal to the target bank, and no refresh issues while it is raised. Once `pre_ack` has been seen with the row closed, the refresh issues in the next cycle, provided the window is free and `sched_act` is low. The refresh never goes to a bank whose `row_open` bit is set.
- R5: Refresh targets follow the order 0, 1, …, NUM_BANKS-1 and then wrap to 0.
- R6: A refresh issues only when fewer than FAW_SLOTS stamps, counting both refreshes and `sched_act` pulses, fall in the preceding FAW_SPAN-1 cycles. It never issues in a cycle where `sched_act` is high.
- R7: During reset, `pre_req`, `ref_cmd`, `faw_stamp` and `bank_blocked` are zero. `ref_bank` and `pre_bank` read 0, and the first refresh targets bank 0.
- R8: A refresh that is held back by a full window is not lost. It issues at a later free cycle, so the number of refreshes still tracks the number of due requests.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| row_open | input | NUM_BANKS | Bit i high: bank i has an open row |
| pre_ack | input | 1 | Precharge of the requested bank is complete |
| sched_act | input | 1 | Scheduler issues an activate this cycle |
| pre_req | output | 1 | Request to precharge bank `pre_bank` |
| pre_bank | output | $clog2(NUM_BANKS) | Bank to precharge |
| ref_cmd | output | 1 | Single-bank refresh command this cycle |
| ref_bank | output | $clog2(NUM_BANKS) | Bank addressed by the refresh |
| bank_blocked | output | NUM_BANKS | One-hot mark of the bank under refresh |
| faw_stamp | output | 1 | Activate-equivalent pulse for the window tracker |

## Verification
The due tick is seen two cycles after the timer wraps, so with a closed bank the spacing between refreshes is exactly REF_INTERVAL cycles. The refresh follows a sampled `pre_ack` by exactly one cycle, and the blocked bit is sampled in each of the PB_BUSY cycles that start at the issue cycle. `faw_stamp` and `ref_cmd` are combinational with respect to `sched_act` and the window state, so the bench changes inputs just after a rising edge and compares all outputs at the following falling edge. The bench keeps its own record of the last four stamp times, and checks every refresh and gates every scheduler activate against that record.

// File: rtl/brs_pkg.sv
package brs_pkg;

    typedef enum logic [1:0] {
        ST_IDLE,
        ST_PRECHARGE,
        ST_WAIT_SLOT,
        ST_BUSY
    } brs_state_e;

endpackage

// File: rtl/brs_interval_timer.sv
// Free-running period counter; pulses tick in the last cycle of each period.
module brs_interval_timer #(
    parameter int PERIOD = 488
) (
    input  logic clk,
    input  logic rst_n,
    output logic tick
);
    localparam int CW = (PERIOD > 2) ? $clog2(PERIOD) : 1;
    localparam logic [CW-1:0] LAST = CW'(PERIOD - 1);

    logic [CW-1:0] cnt_q;

    assign tick = (cnt_q == LAST);

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else if (tick) begin
            cnt_q <= '0;
        end else begin
            cnt_q <= cnt_q + 1'b1;
        end
    end
endmodule

// File: rtl/brs_act_window.sv
// Rolling activate window: one countdown per slot; a stamp seizes the lowest free slot.
module brs_act_window #(
    parameter int SLOTS = 4,
    parameter int SPAN  = 25
) (
    input  logic clk,
    input  logic rst_n,
    input  logic stamp,
    output logic has_room
);
    localparam int TW = (SPAN > 2) ? $clog2(SPAN) : 1;
    localparam logic [TW-1:0] HOLD = TW'(SPAN - 1);

    logic [TW-1:0]    tmr_q [SLOTS];
    logic [SLOTS-1:0] free;
    logic [SLOTS-1:0] grab;

    always_comb begin
        logic taken;
        taken = 1'b0;
        grab  = '0;
        for (int i = 0; i < SLOTS; i++) begin
            free[i] = (tmr_q[i] == '0);
            if (stamp && free[i] && !taken) begin
                grab[i] = 1'b1;
                taken   = 1'b1;
            end
        end
    end

    assign has_room = |free;

    for (genvar g = 0; g < SLOTS; g++) begin : g_slot
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                tmr_q[g] <= '0;
            end else if (grab[g]) begin
                tmr_q[g] <= HOLD;
            end else if (tmr_q[g] != '0) begin
                tmr_q[g] <= tmr_q[g] - 1'b1;
            end
        end
    end
endmodule

// File: rtl/brs_bank_ptr.sv
// Round-robin bank pointer with wrap.
module brs_bank_ptr #(
    parameter int NUM_BANKS = 8,
    localparam int BW = (NUM_BANKS > 1) ? $clog2(NUM_BANKS) : 1
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          advance,
    output logic [BW-1:0] bank
);
    localparam logic [BW-1:0] TOP = BW'(NUM_BANKS - 1);

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            bank <= '0;
        end else if (advance) begin
            bank <= (bank == TOP) ? '0 : bank + 1'b1;
        end
    end
endmodule

// File: rtl/bank_refresh_seq.sv
module bank_refresh_seq
    import brs_pkg::*;
#(
    parameter int NUM_BANKS    = 8,
    parameter int REF_INTERVAL = 488,
    parameter int PB_BUSY      = 45,
    parameter int FAW_SPAN     = 25,
    parameter int FAW_SLOTS    = 4,
    localparam int BW = (NUM_BANKS > 1) ? $clog2(NUM_BANKS) : 1
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic [NUM_BANKS-1:0] row_open,
    input  logic                 pre_ack,
    input  logic                 sched_act,
    output logic                 pre_req,
    output logic [BW-1:0]        pre_bank,
    output logic                 ref_cmd,
    output logic [BW-1:0]        ref_bank,
    output logic [NUM_BANKS-1:0] bank_blocked,
    output logic                 faw_stamp
);
    localparam int CW = (PB_BUSY > 2) ? $clog2(PB_BUSY) : 1;
    localparam logic [CW-1:0] BUSY_LOAD = CW'(PB_BUSY - 2);

    brs_state_e    st_q, st_nxt;
    logic          tick, due_q, has_room, issue, leave_busy;
    logic [BW-1:0] tgt;
    logic [CW-1:0] busy_q;

    brs_interval_timer #(.PERIOD(REF_INTERVAL)) u_timer (
        .clk  (clk),
        .rst_n(rst_n),
        .tick (tick)
    );

    brs_act_window #(.SLOTS(FAW_SLOTS), .SPAN(FAW_SPAN)) u_window (
        .clk     (clk),
        .rst_n   (rst_n),
        .stamp   (issue | sched_act),
        .has_room(has_room)
    );

    brs_bank_ptr #(.NUM_BANKS(NUM_BANKS)) u_ptr (
        .clk    (clk),
        .rst_n  (rst_n),
        .advance(leave_busy),
        .bank   (tgt)
    );

    assign issue      = (st_q == ST_WAIT_SLOT) && !row_open[tgt] && has_room && !sched_act;
    assign leave_busy = (st_q == ST_BUSY) && (busy_q == '0);

    // State register
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q <= ST_IDLE;
        end else begin
            st_q <= st_nxt;
        end
    end

    // Next-state logic
    always_comb begin
        st_nxt = st_q;
        unique case (st_q)
            ST_IDLE: begin
                if (due_q) begin
                    st_nxt = row_open[tgt] ? ST_PRECHARGE : ST_WAIT_SLOT;
                end
            end
            ST_PRECHARGE: begin
                if (pre_ack) begin
                    st_nxt = ST_WAIT_SLOT;
                end
            end
            ST_WAIT_SLOT: begin
                if (row_open[tgt]) begin
                    st_nxt = ST_PRECHARGE;
                end else if (issue) begin
                    st_nxt = ST_BUSY;
                end
            end
            ST_BUSY: begin
                if (busy_q == '0) begin
                    st_nxt = ST_IDLE;
                end
            end
            default: st_nxt = ST_IDLE;
        endcase
    end

    // Pending request flag and busy countdown
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            due_q  <= 1'b0;
            busy_q <= '0;
        end else begin
            if (tick) begin
                due_q <= 1'b1;
            end else if (issue) begin
                due_q <= 1'b0;
            end
            if (issue) begin
                busy_q <= BUSY_LOAD;
            end else if (st_q == ST_BUSY && busy_q != '0) begin
                busy_q <= busy_q - 1'b1;
            end
        end
    end

    // Outputs
    always_comb begin
        pre_req      = (st_q == ST_PRECHARGE);
        pre_bank     = tgt;
        ref_cmd      = issue;
        ref_bank     = tgt;
        faw_stamp    = issue;
        bank_blocked = '0;
        if (issue || st_q == ST_BUSY) begin
            bank_blocked = NUM_BANKS'(1) << tgt;
        end
    end
endmodule

// File: rtl/brs_checker.sv
module brs_checker #(
    parameter int NUM_BANKS = 8,
    parameter int PB_BUSY   = 45,
    parameter int FAW_SPAN  = 25,
    parameter int FAW_SLOTS = 4,
    localparam int BW = (NUM_BANKS > 1) ? $clog2(NUM_BANKS) : 1
) (
    input logic                 clk,
    input logic                 rst_n,
    input logic [NUM_BANKS-1:0] row_open,
    input logic                 sched_act,
    input logic                 pre_req,
    input logic [BW-1:0]        pre_bank,
    input logic                 ref_cmd,
    input logic [BW-1:0]        ref_bank,
    input logic [NUM_BANKS-1:0] bank_blocked,
    input logic                 faw_stamp
);
    localparam logic [BW-1:0] TOP = BW'(NUM_BANKS - 1);

    logic [FAW_SPAN-2:0] hist_q;
    logic [BW-1:0]       last_q, next_bank;
    logic                seen_q;
    logic [15:0]         run_q, run_now;

    assign next_bank = !seen_q ? '0 : ((last_q == TOP) ? '0 : last_q + 1'b1);
    assign run_now   = (bank_blocked != '0) ? run_q + 16'd1 : 16'd0;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            hist_q <= '0;
            last_q <= '0;
            seen_q <= 1'b0;
            run_q  <= '0;
        end else begin
            hist_q <= {hist_q[FAW_SPAN-3:0], ref_cmd | sched_act};
            run_q  <= run_now;
            if (ref_cmd) begin
                last_q <= ref_bank;
                seen_q <= 1'b1;
            end
        end
    end

    a_r2_blocked_onehot: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(bank_blocked));
    a_r2_busy_length: assert property (@(posedge clk) disable iff (!rst_n)
        run_now <= 16'(PB_BUSY));
    a_r3_stamp_with_ref: assert property (@(posedge clk) disable iff (!rst_n)
        ref_cmd |-> (faw_stamp && bank_blocked[ref_bank]));
    a_r4_bank_closed: assert property (@(posedge clk) disable iff (!rst_n)
        ref_cmd |-> !row_open[ref_bank]);
    a_r4_pre_target: assert property (@(posedge clk) disable iff (!rst_n)
        pre_req |-> (pre_bank == next_bank && !ref_cmd));
    a_r5_rotation: assert property (@(posedge clk) disable iff (!rst_n)
        ref_cmd |-> (ref_bank == next_bank));
    a_r6_window_limit: assert property (@(posedge clk) disable iff (!rst_n)
        $countones({hist_q, ref_cmd | sched_act}) <= FAW_SLOTS);
    a_r6_yield_to_act: assert property (@(posedge clk) disable iff (!rst_n)
        ref_cmd |-> !sched_act);
endmodule

bind bank_refresh_seq brs_checker #(
    .NUM_BANKS(NUM_BANKS),
    .PB_BUSY  (PB_BUSY),
    .FAW_SPAN (FAW_SPAN),
    .FAW_SLOTS(FAW_SLOTS)
) u_brs_checker (
    .clk         (clk),
    .rst_n       (rst_n),
    .row_open    (row_open),
    .sched_act   (sched_act),
    .pre_req     (pre_req),
    .pre_bank    (pre_bank),
    .ref_cmd     (ref_cmd),
    .ref_bank    (ref_bank),
    .bank_blocked(bank_blocked),
    .faw_stamp   (faw_stamp)
);

// File: tb/sim_bank_refresh_seq.sv
module sim_bank_refresh_seq;
    localparam int NB    = 8;
    localparam int REFI  = 30;
    localparam int PB    = 7;
    localparam int SPAN  = 11;
    localparam int SLOTS = 4;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic [NB-1:0] row_open = '0;
    logic          pre_ack = 1'b0;
    logic          sched_act = 1'b0;
    logic          pre_req, ref_cmd, faw_stamp;
    logic [2:0]    pre_bank, ref_bank;
    logic [NB-1:0] bank_blocked;

    bank_refresh_seq #(
        .NUM_BANKS(NB), .REF_INTERVAL(REFI), .PB_BUSY(PB),
        .FAW_SPAN(SPAN), .FAW_SLOTS(SLOTS)
    ) u0 (
        .clk(clk), .rst_n(rst_n), .row_open(row_open), .pre_ack(pre_ack),
        .sched_act(sched_act), .pre_req(pre_req), .pre_bank(pre_bank),
        .ref_cmd(ref_cmd), .ref_bank(ref_bank), .bank_blocked(bank_blocked),
        .faw_stamp(faw_stamp)
    );

    always #5 clk = ~clk;

    int n_tests = 0, n_fail = 0;
    int cyc = 0;
    int phase = 0;          // 0 reset, 1 closed, 2 open rows, 3 window load
    int exp_bank = 0;
    int issue_cyc = -1000, issue_bank = 0;
    int last_ref = -1, last_ref_phase = -1;
    int ack_cyc = -10;
    int refs_in_phase [4] = '{0, 0, 0, 0};
    int stamp_t [4] = '{-100, -100, -100, -100};
    bit finished = 0;

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        n_tests++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s cycle %0d: actual %0d expected %0d", req, cyc, act, exp);
        end
    endtask

    function automatic bit room(input int c);
        int oldest = stamp_t[0];
        for (int i = 1; i < 4; i++) if (stamp_t[i] < oldest) oldest = stamp_t[i];
        return oldest <= c - SPAN;
    endfunction

    function automatic void add_stamp(input int c);
        int idx = 0;
        for (int i = 1; i < 4; i++) if (stamp_t[i] < stamp_t[idx]) idx = i;
        stamp_t[idx] = c;
    endfunction

    always @(posedge clk) cyc <= cyc + 1;

    // Precharge responder and scheduler activates
    initial begin
        int wait_n = 0;
        forever begin
            @(posedge clk);
            #1;
            pre_ack = 1'b0;
            sched_act = (phase == 3) && room(cyc) && (cyc % 4 != 0);
            if (pre_req) begin
                wait_n++;
                if (wait_n > (int'(pre_bank) % 4)) begin
                    pre_ack = 1'b1;
                    row_open[pre_bank] = 1'b0;
                    ack_cyc = cyc;
                    wait_n = 0;
                end
            end else begin
                wait_n = 0;
            end
        end
    end

    // Monitor
    always @(negedge clk) begin
        logic [NB-1:0] exp_blk;
        if (!rst_n) begin
            if (cyc == 2) begin
                chk(!pre_req && !ref_cmd && !faw_stamp && bank_blocked == '0, "R7 reset outputs",
                    {pre_req, ref_cmd, faw_stamp}, 0);
                chk(ref_bank == 0 && pre_bank == 0, "R7 reset bank", int'(ref_bank), 0);
            end
        end else if (!finished) begin
            chk(faw_stamp == ref_cmd, "R3 stamp", faw_stamp, ref_cmd);
            if (ref_cmd) begin
                chk(room(cyc), "R6 window room", 0, 1);
                chk(!sched_act, "R6 no same-cycle activate", sched_act, 0);
                chk(int'(ref_bank) == exp_bank, "R5 rotation", int'(ref_bank), exp_bank);
                chk(!row_open[ref_bank], "R4 bank closed", row_open[ref_bank], 0);
                if (phase == 1 && last_ref_phase == 1)
                    chk(cyc - last_ref == REFI, "R1 spacing", cyc - last_ref, REFI);
                issue_cyc = cyc;
                issue_bank = int'(ref_bank);
                exp_bank = (exp_bank + 1) % NB;
                last_ref = cyc;
                last_ref_phase = phase;
                refs_in_phase[phase]++;
            end
            if (pre_req)
                chk(int'(pre_bank) == exp_bank && !ref_cmd, "R4 precharge target",
                    int'(pre_bank), exp_bank);
            if (phase == 2 && ack_cyc == cyc - 1)
                chk(ref_cmd, "R4 refresh after ack", ref_cmd, 1);
            exp_blk = (cyc - issue_cyc < PB) ? (NB'(1) << issue_bank) : '0;
            chk(bank_blocked == exp_blk, "R2 blocked", int'(bank_blocked), int'(exp_blk));
            if (ref_cmd || sched_act) add_stamp(cyc);
        end
    end

    // Watchdog
    initial begin
        repeat (5000) @(posedge clk);
        if (!finished) begin
            finished = 1;
            n_tests++;
            n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
            $finish;
        end
    end

    initial begin
        repeat (4) @(posedge clk);
        #1;
        rst_n = 1'b1;
        phase = 1;
        repeat (11 * REFI) @(posedge clk);
        #1;
        chk(refs_in_phase[1] >= 10, "R1 refresh count", refs_in_phase[1], 10);
        phase = 2;
        row_open = '1;
        repeat (10 * REFI) @(posedge clk);
        #1;
        chk(refs_in_phase[2] >= 9, "R4 refreshes with open rows", refs_in_phase[2], 9);
        row_open = '0;
        phase = 3;
        repeat (10 * REFI) @(posedge clk);
        #1;
        chk(refs_in_phase[3] >= 8, "R8 held refreshes not lost", refs_in_phase[3], 8);
        phase = 0;
        repeat (2 * REFI) @(posedge clk);
        finished = 1;
        $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end
endmodule